// File: doc/BRIEF.md
# Sprite Attribute Page Copy Engine

This block moves one 256-byte page from the processor's address space into the sprite attribute store. The processor starts a copy by writing a page number N to a trigger input. From the next cycle on the engine holds the processor halted. It takes the system bus as master and reads bytes at N*256, N*256+1, and so on up to N*256+255. Each byte it reads is written to the sprite store's write port in the following cycle.

Before the first read the engine spends one idle cycle, or two when the trigger lands on an odd processor cycle. The halt therefore lasts exactly 513 or 514 cycles. A one-cycle done pulse follows the last write. The source page can be anywhere in the address space. A trigger that arrives while a copy is running is ignored.

Top module: `spr_dma_engine`

## Requirements
- R1: After synchronous reset, halt, bus_rd, spr_we and done are all 0.
- R2: If an accepted trigger is sampled with cyc_odd=0, halt is 1 from the next cycle for exactly 513 consecutive cycles and then returns to 0.
- R3: If an accepted trigger is sampled with cyc_odd=1, halt is 1 from the next cycle for exactly 514 consecutive cycles.
- R4: The k-th read cycle (k = 0..255) drives bus_addr = N*256 + k, where N is the page value captured with the trigger.
- R5: After the idle cycles, exactly 256 read cycles (bus_rd=1) and 256 write cycles (spr_we=1) alternate, starting with a read. No cycle has both strobes high.
- R6: In each write cycle, spr_wdata equals the bus_rdata presented during the read cycle just before it.
- R7: Each idle cycle (one for even parity, two for odd) has halt=1, bus_rd=0 and spr_we=0, and all idle cycles come before the first read.
- R8: done is 1 for exactly one cycle, the cycle after the final write, and halt is 0 in that cycle.
- R9: A trigger that arrives while halt=1 has no effect on the running copy's addresses, data or length.
- R10: Page 0xFF copies 0xFF00..0xFFFF; the low address byte wraps nowhere and the page part of bus_addr does not change within a copy.
- R11: Whenever halt is 0, bus_rd and spr_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one processor cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Write strobe of the trigger register |
| trig_page | input | PAGE_W (8) | Source page number N written with the trigger |
| cyc_odd | input | 1 | 1 when the current processor cycle is odd |
| bus_addr | output | ADDR_W (16) | Source address during read cycles |
| bus_rd | output | 1 | Read strobe to the system bus |
| bus_rdata | input | DATA_W (8) | Byte returned by the bus in the read cycle |
| spr_we | output | 1 | Write strobe to the sprite attribute port |
| spr_wdata | output | DATA_W (8) | Byte written to the sprite attribute port |
| halt | output | 1 | Holds the processor suspended during the copy |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The assertions assume that bus_rdata is valid in the same cycle that bus_rd is high. They also assume that cyc_odd and trig_page are stable around the edge that samples trig_we. The bench drives bus_rdata combinationally from bus_addr using a fixed function, so every read returns a byte it can predict. It changes trig_we, trig_page and cyc_odd only on the falling edge. Random runs vary the page and the parity. Directed runs cover page 0x00, page 0xFF with odd parity, and a second trigger in the middle of a copy.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_LEAD  = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4
    } dma_state_e;

    typedef struct packed {
        logic rd;
        logic we;
        logic busy;
    } dma_strobe_t;

    function automatic dma_state_e next_state(input dma_state_e cur,
                                              input logic trig,
                                              input logic odd,
                                              input logic last);
        dma_state_e nxt;
        nxt = cur;
        case (cur)
            ST_IDLE:  if (trig) nxt = odd ? ST_ALIGN : ST_LEAD;
            ST_ALIGN: nxt = ST_LEAD;
            ST_LEAD:  nxt = ST_READ;
            ST_READ:  nxt = ST_WRITE;
            ST_WRITE: nxt = last ? ST_IDLE : ST_READ;
            default:  nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic dma_strobe_t decode_strobe(input dma_state_e cur);
        dma_strobe_t s;
        s.rd   = (cur == ST_READ);
        s.we   = (cur == ST_WRITE);
        s.busy = (cur != ST_IDLE);
        return s;
    endfunction

endpackage

// File: rtl/spr_dma_ctrl.sv
module spr_dma_ctrl
    import spr_dma_pkg::*;
#(
    parameter int BYTE_CNT = 256,
    localparam int CNT_W = $clog2(BYTE_CNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_we,
    input  logic             cyc_odd,
    output dma_state_e       state,
    output logic [CNT_W-1:0] idx,
    output logic             accept,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_CNT - 1);

    logic last;

    assign last   = (idx == LAST_IDX);
    assign accept = (state == ST_IDLE) && trig_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            state <= next_state(state, trig_we, cyc_odd, last);
            done  <= (state == ST_WRITE) && last;
            if (accept)
                idx <= '0;
            else if (state == ST_WRITE && !last)
                idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/spr_dma_addr.sv
module spr_dma_addr #(
    parameter int ADDR_W = 16,
    parameter int BYTE_CNT = 256,
    localparam int CNT_W = $clog2(BYTE_CNT),
    localparam int PAGE_W = ADDR_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (load)
            page_q <= page_in;
    end

    assign addr = {page_q, idx};

endmodule

// File: rtl/spr_dma_latch.sv
module spr_dma_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (capture)
            dout <= din;
    end

endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
    import spr_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BYTE_CNT = 256,
    localparam int CNT_W = $clog2(BYTE_CNT),
    localparam int PAGE_W = ADDR_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_we,
    input  logic [PAGE_W-1:0] trig_page,
    input  logic              cyc_odd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              spr_we,
    output logic [DATA_W-1:0] spr_wdata,
    output logic              halt,
    output logic              done
);
    dma_state_e       state;
    logic [CNT_W-1:0] idx;
    logic             accept;
    dma_strobe_t      strb;

    spr_dma_ctrl #(.BYTE_CNT(BYTE_CNT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .trig_we (trig_we),
        .cyc_odd (cyc_odd),
        .state   (state),
        .idx     (idx),
        .accept  (accept),
        .done    (done)
    );

    spr_dma_addr #(.ADDR_W(ADDR_W), .BYTE_CNT(BYTE_CNT)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .page_in (trig_page),
        .idx     (idx),
        .addr    (bus_addr)
    );

    assign strb = decode_strobe(state);

    spr_dma_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (strb.rd),
        .din     (bus_rdata),
        .dout    (spr_wdata)
    );

    assign bus_rd = strb.rd;
    assign spr_we = strb.we;
    assign halt   = strb.busy;

endmodule

// File: rtl/spr_dma_engine_chk.sv
module spr_dma_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BYTE_CNT = 256,
    localparam int CNT_W = $clog2(BYTE_CNT),
    localparam int HC_W = CNT_W + 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              spr_we,
    input logic [DATA_W-1:0] spr_wdata,
    input logic              halt,
    input logic              done
);
    localparam logic [HC_W-1:0] LEN_EVEN = HC_W'(2 * BYTE_CNT + 1);
    localparam logic [HC_W-1:0] LEN_ODD  = HC_W'(2 * BYTE_CNT + 2);

    logic [HC_W-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst)
            hcnt <= '0;
        else if (halt)
            hcnt <= hcnt + 1'b1;
        else
            hcnt <= '0;
    end

    assert_halt_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> (hcnt == LEN_EVEN || hcnt == LEN_ODD));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && spr_we));

    assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> spr_we);

    assert_data_pass_R6: assert property (@(posedge clk) disable iff (rst)
        spr_we |-> spr_wdata == $past(bus_rdata));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && $past(bus_rd, 2) && $past(halt, 2)) |->
            bus_addr[CNT_W-1:0] == $past(bus_addr[CNT_W-1:0], 2) + 1'b1);

    assert_page_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && $past(bus_rd, 2)) |->
            bus_addr[ADDR_W-1:CNT_W] == $past(bus_addr[ADDR_W-1:CNT_W], 2));

    assert_lead_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> (!bus_rd && !spr_we));

    assert_done_place_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!halt && $past(spr_we)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !halt |-> (!bus_rd && !spr_we));

endmodule

bind spr_dma_engine spr_dma_engine_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_CNT(BYTE_CNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .spr_we    (spr_we),
    .spr_wdata (spr_wdata),
    .halt      (halt),
    .done      (done)
);

// File: tb/spr_dma_engine_test.sv
`timescale 1ns/1ps
module spr_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        trig_we;
    logic [7:0]  trig_page;
    logic        cyc_odd;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        spr_we;
    logic [7:0]  spr_wdata;
    logic        halt;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd37;
        return m ^ a[15:8] ^ 8'hA5;
    endfunction

    assign bus_rdata = bus_rd ? src_byte(bus_addr) : 8'h00;

    spr_dma_engine uut (
        .clk(clk), .rst(rst), .trig_we(trig_we), .trig_page(trig_page),
        .cyc_odd(cyc_odd), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .spr_we(spr_we), .spr_wdata(spr_wdata),
        .halt(halt), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // One full copy; inj > 0 places a second trigger in that cycle (R9).
    task automatic run_copy(input logic [7:0] page, input bit odd, input int inj);
        int lead;
        int total;
        lead  = odd ? 2 : 1;
        total = lead + 512;
        @(negedge clk);
        trig_we = 1'b1; trig_page = page; cyc_odd = odd;
        for (int c = 1; c <= total + 2; c++) begin
            @(negedge clk);
            if (c == 1) trig_we = 1'b0;
            cyc_odd = 1'($urandom);
            if (inj > 0 && c == inj) begin trig_we = 1'b1; trig_page = ~page; end
            if (inj > 0 && c == inj + 1) trig_we = 1'b0;
            if (c <= total) begin
                chk(halt == 1'b1, odd ? "R3 halt held" : "R2 halt held", halt, 1);
                if (c <= lead) begin
                    chk(!bus_rd && !spr_we, "R7 idle lead", {bus_rd, spr_we}, 0);
                end else begin
                    int k;
                    logic [15:0] ea;
                    k  = c - lead - 1;
                    ea = {page, 8'(k / 2)};
                    if (k % 2 == 0) begin
                        chk(bus_rd && !spr_we, "R5 read slot", {bus_rd, spr_we}, 2);
                        chk(bus_addr == ea, inj > 0 ? "R9 addr" : (page == 8'hFF ? "R10 addr" : "R4 addr"), bus_addr, ea);
                    end else begin
                        chk(spr_we && !bus_rd, "R5 write slot", {bus_rd, spr_we}, 1);
                        chk(spr_wdata == src_byte(ea), "R6 data", spr_wdata, src_byte(ea));
                    end
                end
            end else if (c == total + 1) begin
                chk(halt == 1'b0, odd ? "R3 halt release" : "R2 halt release", halt, 0);
                chk(done == 1'b1, "R8 done pulse", done, 1);
                chk(!bus_rd && !spr_we, "R11 quiet", {bus_rd, spr_we}, 0);
            end else begin
                chk(done == 1'b0, "R8 done single", done, 0);
                chk(halt == 1'b0, "R9 no restart", halt, 0);
            end
        end
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        rst = 1'b1; trig_we = 1'b0; trig_page = 8'h00; cyc_odd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(halt == 1'b0 && done == 1'b0, "R1 reset halt/done", {halt, done}, 0);
        chk(!bus_rd && !spr_we, "R1 reset strobes", {bus_rd, spr_we}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(halt == 1'b0, "R11 idle no halt", halt, 0);
        run_copy(8'h00, 1'b0, 0);
        run_copy(8'hFF, 1'b1, 0);
        run_copy(8'h80, 1'b0, 100);
        run_copy(8'h3C, 1'b1, 2);
        for (int r = 0; r < 8; r++) begin
            run_copy(8'($urandom), 1'($urandom), (r % 3 == 0) ? int'($urandom_range(1, 500)) : 0);
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule